// File: doc/BRIEF.md
# Static Memory Write Strobe Sequencer

This block produces the external pin waveforms for a single write to an asynchronous static memory or memory-mapped peripheral. It drives a set of active-low chip-select lines, a write-enable strobe, two per-byte lane signals, the address, the write data and the enable for the data bus drivers. Each chip select has its own timing set. The set holds separate setup and pulse counts for the chip-select strobe and for the write-enable strobe, and one total cycle length. All of these are counted in system clocks. The hold phase of each strobe is never programmed. It is whatever remains of the cycle after that strobe's setup and pulse.

On the internal side, a write request is a valid/ready transfer carrying the chip-select index, address, data and byte mask. `req_ready` is high while the sequencer is idle and in the final clock of every bus cycle. Outside those clocks it is low, and that is the only back-pressure. A requester holds `req_valid` and its payload until it sees `req_ready`. The request transfers on the clock edge where both are high.

The bus cycle starts on the clock that follows the transfer, and a request accepted in the final clock of a write starts its own cycle with no gap. A plain configuration write port loads one chip select's timing set per clock. A write already on the bus keeps the timing set it captured when it started.

Top module: `smcw_write_seq`

## Requirements
- R1: After reset, all `bus_ncs` lines, `bus_nwe` and both `bus_nbyte` lines are high, `bus_oe` is low and `req_ready` is high. Every chip select holds the default set: both setups 0, both pulses 1, cycle 1, `cfg_oe_by_we`=1, `cfg_byte_strobes`=0.
- R2: A clock with `cfg_we` high stores the fields on the cfg ports as the timing set of chip select `cfg_sel` only. A bus cycle uses the set that its chip select held when the cycle was accepted.
- R3: The cycle lasts L clocks, where L is the largest of: the cycle count, write setup plus write pulse, select setup plus select pulse, and 1. Cycle index 0 is the clock after the transfer.
- R4: `bus_addr` carries the request address and `bus_data` carries the request data, unchanged for all L clocks of the cycle.
- R5: Line `bus_ncs[req_cs]` is low exactly at cycle indices k with select setup ≤ k < select setup + select pulse. It never goes low when the select pulse is 0. All other select lines stay high.
- R6: The write-enable strobe is active exactly at indices k with write setup ≤ k < write setup + write pulse. It is never active when the write pulse is 0. In byte-select mode this strobe appears on `bus_nwe`.
- R7: `bus_oe` rises at index (write setup) when `cfg_oe_by_we`=1 and at index (select setup) when it is 0. Once high it stays high to index L-1, whatever either strobe does.
- R8: In byte-select mode (`cfg_byte_strobes`=0), `bus_nbyte[i]` equals the inverse of mask bit i for the whole cycle. In per-byte strobe mode (=1), `bus_nbyte[i]` is low only while the write-enable strobe is active and mask bit i is 1, and `bus_nwe` stays high. Lane 0 is `bus_data[7:0]`.
- R9: `req_ready` is high in cycle index L-1 and low at indices 0 to L-2. A request transferred at index L-1 starts its cycle on the next clock.
- R10: Outside a bus cycle, all strobes and lane signals are high and `bus_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load timing set for `cfg_sel` |
| cfg_sel | input | IDX_W (2) | Chip select being configured |
| cfg_we_setup | input | 6 | Write-enable setup clocks |
| cfg_we_pulse | input | 6 | Write-enable pulse clocks |
| cfg_cs_setup | input | 6 | Chip-select setup clocks |
| cfg_cs_pulse | input | 6 | Chip-select pulse clocks |
| cfg_cycle | input | 7 | Total cycle clocks |
| cfg_oe_by_we | input | 1 | 1: write-enable setup opens data drive; 0: chip-select setup does |
| cfg_byte_strobes | input | 1 | 1: lane lines are per-byte write strobes; 0: byte selects |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_cs | input | IDX_W (2) | Target chip select |
| req_addr | input | ADDR_W (24) | Write address |
| req_data | input | DATA_W (16) | Write data |
| req_mask | input | NB (2) | Byte enables, bit i for lane i |
| bus_addr | output | ADDR_W (24) | External address |
| bus_data | output | DATA_W (16) | External write data |
| bus_oe | output | 1 | Data bus driver enable |
| bus_ncs | output | NUM_CS (4) | Active-low chip selects |
| bus_nwe | output | 1 | Active-low write enable |
| bus_nbyte | output | NB (2) | Active-low byte selects or byte write strobes |

## Verification
The bound checker watches every clock for properties that need no knowledge of the timing set. At most one select line is low. Address and data hold across a cycle. The data drive, once open, stays open to the end of the cycle. The pins are quiet while idle. After the ready clock, either the sequencer goes idle or a new cycle restarts at index 0. Everything else depends on the programmed counts, so only the bench's scenarios can show it: where each strobe edge lands, how long the cycle lasts, the clamp when setup plus pulse exceeds the cycle, zero-length pulses, both data-drive modes, both lane modes, back-to-back writes, and a configuration change during a write.

// File: rtl/smcw_pkg.sv
`timescale 1ns/1ps
package smcw_pkg;
  localparam int SET_W = 6;
  localparam int PUL_W = 6;
  localparam int CYC_W = 7;
  localparam int CNT_W = CYC_W + 1;

  typedef struct packed {
    logic [SET_W-1:0] we_setup;
    logic [PUL_W-1:0] we_pulse;
    logic [SET_W-1:0] cs_setup;
    logic [PUL_W-1:0] cs_pulse;
    logic [CYC_W-1:0] cycle;
    logic             oe_by_we;
    logic             byte_strobes;
  } wr_timing_t;

  localparam wr_timing_t CFG_RESET = '{
    we_setup: '0, we_pulse: PUL_W'(1), cs_setup: '0, cs_pulse: PUL_W'(1),
    cycle: CYC_W'(1), oe_by_we: 1'b1, byte_strobes: 1'b0};

  // longest of programmed cycle and either strobe's setup+pulse, at least one
  function automatic logic [CNT_W-1:0] cycle_len(wr_timing_t c);
    logic [CNT_W-1:0] we_end, cs_end, len;
    we_end = CNT_W'(c.we_setup) + CNT_W'(c.we_pulse);
    cs_end = CNT_W'(c.cs_setup) + CNT_W'(c.cs_pulse);
    len    = CNT_W'(c.cycle);
    if (we_end > len) len = we_end;
    if (cs_end > len) len = cs_end;
    if (len == '0) len = CNT_W'(1);
    return len;
  endfunction
endpackage

// File: rtl/smcw_cfg_regs.sv
`timescale 1ns/1ps
module smcw_cfg_regs
  import smcw_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  wr_timing_t       wr_set,
  input  logic [IDX_W-1:0] rd_idx,
  output wr_timing_t       rd_set
);
  wr_timing_t bank [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                bank[g] <= CFG_RESET;
      else if (wr_en && wr_idx == IDX_W'(g))     bank[g] <= wr_set;
    end
  end

  assign rd_set = bank[rd_idx];
endmodule

// File: rtl/smcw_phase_decode.sv
`timescale 1ns/1ps
module smcw_phase_decode
  import smcw_pkg::*;
#(
  parameter int NB = 2
) (
  input  logic             active,
  input  logic [CNT_W-1:0] idx,
  input  wr_timing_t       set,
  input  logic [NB-1:0]    mask,
  output logic             cs_on,
  output logic             nwe,
  output logic [NB-1:0]    nbyte,
  output logic             oe
);
  logic [CNT_W-1:0] cs_lo, cs_hi, we_lo, we_hi, oe_lo;
  logic             we_on;

  always_comb begin
    cs_lo = CNT_W'(set.cs_setup);
    cs_hi = cs_lo + CNT_W'(set.cs_pulse);
    we_lo = CNT_W'(set.we_setup);
    we_hi = we_lo + CNT_W'(set.we_pulse);
    oe_lo = set.oe_by_we ? we_lo : cs_lo;

    cs_on = active && (idx >= cs_lo) && (idx < cs_hi);
    we_on = active && (idx >= we_lo) && (idx < we_hi);
    oe    = active && (idx >= oe_lo);

    if (set.byte_strobes) begin
      nwe   = 1'b1;
      nbyte = ~({NB{we_on}} & mask);
    end else begin
      nwe   = ~we_on;
      nbyte = active ? ~mask : '1;
    end
  end
endmodule

// File: rtl/smcw_write_seq.sv
`timescale 1ns/1ps
module smcw_write_seq
  import smcw_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int NB    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_sel,
  input  logic [SET_W-1:0]  cfg_we_setup,
  input  logic [PUL_W-1:0]  cfg_we_pulse,
  input  logic [SET_W-1:0]  cfg_cs_setup,
  input  logic [PUL_W-1:0]  cfg_cs_pulse,
  input  logic [CYC_W-1:0]  cfg_cycle,
  input  logic              cfg_oe_by_we,
  input  logic              cfg_byte_strobes,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_cs,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [NB-1:0]     req_mask,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_oe,
  output logic [NUM_CS-1:0] bus_ncs,
  output logic              bus_nwe,
  output logic [NB-1:0]     bus_nbyte
);
  wr_timing_t cfg_wset, cfg_rd;

  assign cfg_wset = '{we_setup: cfg_we_setup, we_pulse: cfg_we_pulse,
                      cs_setup: cfg_cs_setup, cs_pulse: cfg_cs_pulse,
                      cycle: cfg_cycle, oe_by_we: cfg_oe_by_we,
                      byte_strobes: cfg_byte_strobes};

  smcw_cfg_regs #(.NUM_CS(NUM_CS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_sel),
    .wr_set(cfg_wset), .rd_idx(req_cs), .rd_set(cfg_rd));

  // cycle state
  logic             active_q, active_n;
  logic [CNT_W-1:0] t_q, t_n, len_q, len_n;
  wr_timing_t       set_q, set_n;
  logic [IDX_W-1:0] cs_q, cs_n;
  logic [NB-1:0]    mask_q, mask_n;
  logic             last, hs;

  assign last      = active_q && (t_q == len_q - CNT_W'(1));
  assign req_ready = !active_q || last;
  assign hs        = req_valid && req_ready;

  always_comb begin
    active_n = active_q;
    t_n      = t_q;
    len_n    = len_q;
    set_n    = set_q;
    cs_n     = cs_q;
    mask_n   = mask_q;
    if (hs) begin
      active_n = 1'b1;
      t_n      = '0;
      set_n    = cfg_rd;
      len_n    = cycle_len(cfg_rd);
      cs_n     = req_cs;
      mask_n   = req_mask;
    end else if (last) begin
      active_n = 1'b0;
    end else if (active_q) begin
      t_n = t_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      t_q      <= '0;
      len_q    <= CNT_W'(1);
      set_q    <= CFG_RESET;
      cs_q     <= '0;
      mask_q   <= '0;
      bus_addr <= '0;
      bus_data <= '0;
    end else begin
      active_q <= active_n;
      t_q      <= t_n;
      len_q    <= len_n;
      set_q    <= set_n;
      cs_q     <= cs_n;
      mask_q   <= mask_n;
      if (hs) begin
        bus_addr <= req_addr;
        bus_data <= req_data;
      end
    end
  end

  // pins are registered from the decode of the next state
  logic          cs_on_n, nwe_n, oe_n;
  logic [NB-1:0] nbyte_n;

  smcw_phase_decode #(.NB(NB)) u_dec (
    .active(active_n), .idx(t_n), .set(set_n), .mask(mask_n),
    .cs_on(cs_on_n), .nwe(nwe_n), .nbyte(nbyte_n), .oe(oe_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_oe    <= 1'b0;
      bus_nwe   <= 1'b1;
      bus_nbyte <= '1;
    end else begin
      bus_oe    <= oe_n;
      bus_nwe   <= nwe_n;
      bus_nbyte <= nbyte_n;
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ncs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_ncs[g] <= 1'b1;
      else        bus_ncs[g] <= ~(cs_on_n && cs_n == IDX_W'(g));
    end
  end
endmodule

// File: rtl/smcw_checker.sv
`timescale 1ns/1ps
module smcw_checker
  import smcw_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  localparam int NB = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              active_q,
  input logic [CNT_W-1:0]  t_q,
  input logic              req_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_oe,
  input logic [NUM_CS-1:0] bus_ncs,
  input logic              bus_nwe,
  input logic [NB-1:0]     bus_nbyte
);
  a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_ncs));

  a_r4_bus_held: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && t_q != '0) |-> ($stable(bus_addr) && $stable(bus_data)));

  a_r7_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && t_q != '0 && $past(bus_oe)) |-> bus_oe);

  a_r9_ready_then_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && req_ready) |=> (!active_q || t_q == '0));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (!bus_oe && (&bus_ncs) && bus_nwe && (&bus_nbyte)));
endmodule

bind smcw_write_seq smcw_checker #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .active_q(active_q), .t_q(t_q), .req_ready(req_ready),
  .bus_addr(bus_addr), .bus_data(bus_data), .bus_oe(bus_oe), .bus_ncs(bus_ncs),
  .bus_nwe(bus_nwe), .bus_nbyte(bus_nbyte));

// File: tb/sim_smcw_write_seq.sv
`timescale 1ns/1ps
module sim_smcw_write_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [5:0]  cfg_we_setup = '0, cfg_we_pulse = '0, cfg_cs_setup = '0, cfg_cs_pulse = '0;
  logic [6:0]  cfg_cycle = '0;
  logic        cfg_oe_by_we = 1'b0, cfg_byte_strobes = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_cs = '0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic [1:0]  req_mask = '0;
  logic [23:0] bus_addr;
  logic [15:0] bus_data;
  logic        bus_oe, bus_nwe;
  logic [3:0]  bus_ncs;
  logic [1:0]  bus_nbyte;

  smcw_write_seq u0 (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int m_ws[4], m_wp[4], m_cs[4], m_cp[4], m_cyc[4], m_oe[4], m_bs[4];

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_len(int c);
    int l = m_cyc[c];
    if (m_ws[c] + m_wp[c] > l) l = m_ws[c] + m_wp[c];
    if (m_cs[c] + m_cp[c] > l) l = m_cs[c] + m_cp[c];
    if (l < 1) l = 1;
    return l;
  endfunction

  task automatic set_cfg(int c, int ws, int wp, int cs, int cp, int cyc, int oe, int bs);
    @(negedge clk);
    cfg_sel = 2'(c); cfg_we_setup = 6'(ws); cfg_we_pulse = 6'(wp);
    cfg_cs_setup = 6'(cs); cfg_cs_pulse = 6'(cp); cfg_cycle = 7'(cyc);
    cfg_oe_by_we = oe[0]; cfg_byte_strobes = bs[0]; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    m_ws[c] = ws; m_wp[c] = wp; m_cs[c] = cs; m_cp[c] = cp;
    m_cyc[c] = cyc; m_oe[c] = oe; m_bs[c] = bs;
  endtask

  task automatic check_idle();
    check("R10 idle ncs", bus_ncs, 4'hf);
    check("R10 idle nwe", bus_nwe, 1);
    check("R10 idle nbyte", bus_nbyte, 2'b11);
    check("R10 idle oe", bus_oe, 0);
    check("R9 idle ready", req_ready, 1);
  endtask

  // called at a negedge; returns at the negedge of the last cycle index
  task automatic issue(int c, logic [23:0] a, logic [15:0] d, logic [1:0] m, bit mid_cfg);
    int ws = m_ws[c], wp = m_wp[c], cs = m_cs[c], cp = m_cp[c];
    int oe = m_oe[c], bs = m_bs[c], len = exp_len(c);
    req_cs = 2'(c); req_addr = a; req_data = d; req_mask = m; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < len; k++) begin
      bit cs_on = (k >= cs) && (k < cs + cp);
      bit we_on = (k >= ws) && (k < ws + wp);
      bit oe_on = (k >= (oe ? ws : cs));
      logic [3:0] e_ncs = 4'hf;
      logic [1:0] e_nb;
      if (cs_on) e_ncs[c] = 1'b0;
      e_nb = bs ? ~({2{we_on}} & m) : ~m;
      check("R5 ncs", bus_ncs, e_ncs);
      check("R6 nwe", bus_nwe, bs ? 1 : !we_on);
      check("R8 nbyte", bus_nbyte, e_nb);
      check("R7 oe", bus_oe, oe_on);
      check("R4 addr", bus_addr, a);
      if (oe_on) check("R4 data", bus_data, d);
      check("R9 ready", req_ready, k == len - 1);
      if (mid_cfg && k == 0) begin
        cfg_sel = 2'(c); cfg_we_setup = 6'd9; cfg_we_pulse = 6'd9; cfg_cs_setup = 6'd9;
        cfg_cs_pulse = 6'd9; cfg_cycle = 7'd30; cfg_oe_by_we = 1'b0;
        cfg_byte_strobes = 1'b1; cfg_we = 1'b1;
      end
      if (mid_cfg && k == 1) begin
        cfg_we = 1'b0;
        m_ws[c] = 9; m_wp[c] = 9; m_cs[c] = 9; m_cp[c] = 9;
        m_cyc[c] = 30; m_oe[c] = 0; m_bs[c] = 1;
      end
      if (k < len - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int len;
    for (int c = 0; c < 4; c++) begin
      m_ws[c] = 0; m_wp[c] = 1; m_cs[c] = 0; m_cp[c] = 1; m_cyc[c] = 1; m_oe[c] = 1; m_bs[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle();                                    // R1 reset pins
    issue(2, 24'h00abcd, 16'h1234, 2'b11, 0);        // R1 default set: one-clock cycle
    @(negedge clk); check_idle();

    // R3 clamp: setup+pulse beyond cycle count
    set_cfg(0, 2, 4, 1, 3, 3, 1, 0);
    issue(0, 24'h000100, 16'hbeef, 2'b01, 0);
    @(negedge clk); check_idle();
    // R5/R6 zero pulses, R7 mode 0, long hold
    set_cfg(1, 1, 0, 3, 2, 12, 0, 0);
    issue(1, 24'h222222, 16'h5a5a, 2'b10, 0);
    set_cfg(1, 4, 3, 2, 0, 10, 1, 1);                // R8 byte strobes
    issue(1, 24'h333333, 16'ha5a5, 2'b10, 0);
    // R9 back-to-back across chip selects, no gap
    set_cfg(3, 0, 2, 1, 2, 5, 0, 1);
    issue(3, 24'h444444, 16'h0f0f, 2'b11, 0);
    issue(0, 24'h555555, 16'hf0f0, 2'b10, 0);
    issue(3, 24'h666666, 16'h3c3c, 2'b01, 0);
    @(negedge clk); check_idle();
    // R2 config change during a write affects only the next one
    set_cfg(2, 1, 2, 0, 4, 6, 1, 0);
    issue(2, 24'h777777, 16'h7777, 2'b11, 1);
    issue(2, 24'h888888, 16'h8888, 2'b01, 0);
    @(negedge clk); check_idle();
    // R2 independence: cs0 still has its own set
    issue(0, 24'h999999, 16'h9999, 2'b11, 0);

    // random mix
    void'($urandom(32'd20240611));
    for (int i = 0; i < 300; i++) begin
      int c = $urandom_range(0, 3);
      if ($urandom_range(0, 3) == 0)
        set_cfg(c, $urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 5),
                $urandom_range(0, 5), $urandom_range(0, 12), $urandom_range(0, 1),
                $urandom_range(0, 1));
      if ($urandom_range(0, 1) == 0) begin
        @(negedge clk); check_idle();
      end
      issue(c, 24'($urandom), 16'($urandom), 2'($urandom_range(0, 3)), 0);
    end
    @(negedge clk); check_idle();
    len = n_chk;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", len, n_bad);
    $finish;
  end
endmodule